// File: doc/BRIEF.md
# Periodic Ping Synchroniser and Capture Scheduler

This block decides when a sample capture path records data. A sonar beacon emits a ping at a fixed period. At the start the block knows nothing about the ping's phase. It therefore holds capture open for one long search window. During that window it keeps the timestamp of the earliest sample whose magnitude reaches a threshold that software sets. From that timestamp it predicts the next ping. Capture is then switched off until a guard time before the prediction, and only a short tracking window is opened. Each ping found in a tracking window sets up the next window. A tracking window that sees no ping sends the block back to search.

A debug input overrides the locking behaviour. While it is set, capture stays on continuously and no ping detection takes place. A marker pulse is issued at the end of every fixed-length dump window. All durations are counted in sample strobes and are set by parameters. The defaults assume a 5 MHz sample rate: a 2.2 s search, a 250 ms track, a 2.1 s dump, a 2 s period and a 50 ms guard. Timestamps come from a free-running 32-bit count of sample strobes.

Top module: `ping_sync_sched`

## Requirements
- R1: The timestamp of a sample is the number of strobes seen since reset before it. The count is 32 bits wide and wraps. The first strobe after reset has timestamp 0.
- R2: While unlocked, the block captures a search window of SEARCH_LEN consecutive strobes with `cap_en`=1 and `locked`=0. It repeats the search window while no crossing occurs.
- R3: A crossing is a captured strobe with `smp_mag` >= `thresh`, both compared as unsigned values. Within a window only the first crossing is reported. `ping_vld` pulses for one clock, the clock after that strobe, and `ping_ts` then holds that strobe's timestamp until the next report.
- R4: When a window that holds a crossing ends at timestamp E, the next window opens at O = T + PERIOD - GUARD, where T is the crossing's timestamp. If O <= E+1, then O is replaced by O + PERIOD. Between the end of the window and O, `cap_en`=0 and `locked`=1.
- R5: A tracking window spans TRACK_LEN strobes. Its first strobe has timestamp O. While it is open, `cap_en`=1 and `locked`=1. If the window holds a crossing, the next window is scheduled under R4.
- R6: If a tracking window holds no crossing, a new search window starts with the next strobe, and `locked` returns to 0.
- R7: While `debug_en`=1, `cap_en`=1 and `locked`=0, and no `ping_vld` is produced. `dump_pulse` pulses for one clock after every DEBUG_LEN-th strobe. Window counting restarts at the clock where debug mode is entered.
- R8: When `debug_en` falls, a fresh search window begins with the next strobe.
- R9: After reset, `cap_en`=1, `locked`=0, `ping_vld`=0, `dump_pulse`=0 and `ping_ts`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-clock strobe per sample |
| smp_mag | input | MAG_W | Sample magnitude, valid with the strobe |
| thresh | input | MAG_W | Crossing threshold |
| debug_en | input | 1 | Continuous dump mode |
| cap_en | output | 1 | Capture path records strobes while high |
| locked | output | 1 | Tracking schedule is active |
| ping_vld | output | 1 | Pulse: new ping timestamp reported |
| ping_ts | output | 32 | Timestamp of the last reported ping |
| dump_pulse | output | 1 | Pulse: debug dump window complete |

## Verification
A wrong window length or schedule changes the sample indices at which `cap_en` toggles. It therefore shows up as a wrong captured-sample count over a span, or as `cap_en` at the wrong level at a probed sample, within one window of the fault. Lost or extra detections appear at once as `ping_vld` pulses with a timestamp that does not match the predicted ping, or as pulses inside wait or debug spans. A missed fallback leaves `locked` high and `cap_en` low at samples where a search should be running. That is visible within one period.

// File: rtl/ps_pkg.sv
package ps_pkg;

  localparam int TS_W = 32;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_WAIT   = 2'd1,
    ST_TRACK  = 2'd2,
    ST_DEBUG  = 2'd3
  } sync_state_e;

  // Open time of the next window: one period after the hit, less the guard.
  // If that is not at least two strobes past the window end, skip one period.
  function automatic logic [TS_W-1:0] sched_open(
    input logic [TS_W-1:0] hit_ts,
    input logic [TS_W-1:0] end_ts,
    input logic [TS_W-1:0] period,
    input logic [TS_W-1:0] guard
  );
    logic [TS_W-1:0] open_t;
    logic [TS_W-1:0] gap;
    open_t = hit_ts + period - guard;
    gap    = open_t - end_ts - TS_W'(1);
    if ($signed(gap) <= 0) open_t = open_t + period;
    return open_t;
  endfunction

endpackage

// File: rtl/ps_ts_counter.sv
module ps_ts_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  output logic [TS_W-1:0] ts_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)   ts_o <= '0;
    else if (stb) ts_o <= ts_o + TS_W'(1);
  end

  a_r1_ts_advance: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (ts_o == $past(ts_o) + TS_W'(1)));

  a_r1_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(ts_o));

endmodule

// File: rtl/ps_win_counter.sv
module ps_win_counter #(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             en,
  input  logic             clr,
  input  logic [WIN_W-1:0] len,
  output logic             last_o
);

  logic [WIN_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == len - WIN_W'(1));
  assign last_o = stb && en && !clr && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (stb && en) begin
      if (at_end)           cnt_q <= '0;
      else                  cnt_q <= cnt_q + WIN_W'(1);
    end
  end

  // The count never runs past the window that is selected.
  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < len));

endmodule

// File: rtl/ps_first_hit.sv
module ps_first_hit #(
  parameter int MAG_W = 14,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             en,
  input  logic             abort,
  input  logic             clr,
  input  logic [MAG_W-1:0] mag,
  input  logic [MAG_W-1:0] thresh,
  input  logic [TS_W-1:0]  ts,
  output logic             found_now_o,
  output logic [TS_W-1:0]  hit_ts_now_o,
  output logic             vld_o,
  output logic [TS_W-1:0]  ts_o
);

  logic found_q;
  logic hit;

  assign hit          = stb && en && !abort && !found_q && (mag >= thresh);
  assign found_now_o  = found_q || hit;
  assign hit_ts_now_o = hit ? ts : ts_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      vld_o   <= 1'b0;
      ts_o    <= '0;
    end else begin
      vld_o <= hit;
      if (hit) ts_o <= ts;
      if (abort || clr) found_q <= 1'b0;
      else if (hit)     found_q <= 1'b1;
    end
  end

  // Once a window holds a crossing, no further report comes from it.
  a_r3_one_per_window: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && !clr && !abort) |=> !vld_o);

  a_r3_ts_latched: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (ts_o == $past(ts)));

endmodule

// File: rtl/ping_sync_sched.sv
module ping_sync_sched #(
  parameter int MAG_W      = 14,
  parameter int SEARCH_LEN = 11000000,
  parameter int TRACK_LEN  = 1250000,
  parameter int DEBUG_LEN  = 10500000,
  parameter int PERIOD     = 10000000,
  parameter int GUARD      = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic [MAG_W-1:0] smp_mag,
  input  logic [MAG_W-1:0] thresh,
  input  logic             debug_en,
  output logic             cap_en,
  output logic             locked,
  output logic             ping_vld,
  output logic [31:0]      ping_ts,
  output logic             dump_pulse
);

  import ps_pkg::*;

  localparam int LEN_A   = (SEARCH_LEN > DEBUG_LEN) ? SEARCH_LEN : DEBUG_LEN;
  localparam int MAX_LEN = (LEN_A > TRACK_LEN) ? LEN_A : TRACK_LEN;
  localparam int WIN_W   = $clog2(MAX_LEN + 1);

  sync_state_e     state_q, state_d;
  logic [TS_W-1:0] open_q, open_d;
  logic [TS_W-1:0] ts_now;
  logic [TS_W-1:0] hit_ts_now;
  logic [WIN_W-1:0] win_len;
  logic            mode_sw;
  logic            in_debug;
  logic            capturing;
  logic            detecting;
  logic            win_clr;
  logic            win_last;
  logic            found_now;
  logic            open_hit;
  logic            dump_q;

  // Named internal events
  assign in_debug  = (state_q == ST_DEBUG);
  assign mode_sw   = debug_en != in_debug;
  assign capturing = (state_q != ST_WAIT);
  assign detecting = (state_q == ST_SEARCH) || (state_q == ST_TRACK);
  assign win_clr   = mode_sw || (state_q == ST_WAIT);
  assign open_hit  = smp_stb && (state_q == ST_WAIT) && (ts_now + TS_W'(1) == open_q);

  always_comb begin
    case (state_q)
      ST_TRACK: win_len = WIN_W'(TRACK_LEN);
      ST_DEBUG: win_len = WIN_W'(DEBUG_LEN);
      default:  win_len = WIN_W'(SEARCH_LEN);
    endcase
  end

  ps_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (smp_stb),
    .ts_o  (ts_now)
  );

  ps_win_counter #(.WIN_W(WIN_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (smp_stb),
    .en     (capturing),
    .clr    (win_clr),
    .len    (win_len),
    .last_o (win_last)
  );

  ps_first_hit #(.MAG_W(MAG_W), .TS_W(TS_W)) u_hit (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (smp_stb),
    .en           (detecting),
    .abort        (win_clr),
    .clr          (win_last),
    .mag          (smp_mag),
    .thresh       (thresh),
    .ts           (ts_now),
    .found_now_o  (found_now),
    .hit_ts_now_o (hit_ts_now),
    .vld_o        (ping_vld),
    .ts_o         (ping_ts)
  );

  always_comb begin
    state_d = state_q;
    open_d  = open_q;
    if (mode_sw) begin
      state_d = debug_en ? ST_DEBUG : ST_SEARCH;
    end else begin
      case (state_q)
        ST_SEARCH, ST_TRACK: begin
          if (win_last) begin
            if (found_now) begin
              state_d = ST_WAIT;
              open_d  = sched_open(hit_ts_now, ts_now, TS_W'(PERIOD), TS_W'(GUARD));
            end else begin
              state_d = ST_SEARCH;
            end
          end
        end
        ST_WAIT:  if (open_hit) state_d = ST_TRACK;
        default:  state_d = ST_DEBUG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      open_q  <= '0;
      dump_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      open_q  <= open_d;
      dump_q  <= in_debug && win_last;
    end
  end

  assign cap_en     = capturing;
  assign locked     = (state_q == ST_WAIT) || (state_q == ST_TRACK);
  assign dump_pulse = dump_q;

  a_r5_track_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRACK && $past(state_q) != ST_TRACK) |-> ($past(state_q) == ST_WAIT));

  a_r6_fallback_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEARCH && $past(state_q) == ST_TRACK) |-> $past(win_last && !found_now));

  a_r4_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && $past(state_q) == ST_WAIT) |-> !ping_vld);

  a_r7_debug_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEBUG && $past(state_q) == ST_DEBUG) |-> !ping_vld);

  a_r7_dump_from_debug: assert property (@(posedge clk) disable iff (!rst_n)
    dump_pulse |-> ($past(state_q) == ST_DEBUG));

  a_r8_debug_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_DEBUG && state_q != ST_DEBUG) |-> (state_q == ST_SEARCH));

endmodule

// File: tb/tb_ping_sync_sched.sv
module tb_ping_sync_sched;

  localparam int CLK_NS  = 10;
  localparam int MAG_W   = 14;
  localparam int S_LEN   = 110;
  localparam int T_LEN   = 30;
  localparam int D_LEN   = 105;
  localparam int PER     = 100;
  localparam int GRD     = 10;
  localparam int THR     = 1000;
  localparam int N_SMP   = 1500;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_stb = 1'b0;
  logic [MAG_W-1:0] smp_mag = '0;
  logic [MAG_W-1:0] thresh = MAG_W'(THR);
  logic             debug_en = 1'b0;
  logic             cap_en, locked, ping_vld, dump_pulse;
  logic [31:0]      ping_ts;

  int n_chk = 0;
  int n_fail = 0;
  int cur_idx = -1;
  bit finished = 1'b0;
  int exp_ping[$];
  int exp_dump[$];
  int cap_a = 0;
  int cap_b = 0;
  int cap_c = 0;

  always #(CLK_NS/2) clk = ~clk;

  ping_sync_sched #(
    .MAG_W(MAG_W), .SEARCH_LEN(S_LEN), .TRACK_LEN(T_LEN),
    .DEBUG_LEN(D_LEN), .PERIOD(PER), .GUARD(GRD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_mag(smp_mag),
    .thresh(thresh), .debug_en(debug_en), .cap_en(cap_en), .locked(locked),
    .ping_vld(ping_vld), .ping_ts(ping_ts), .dump_pulse(dump_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ping train A: phase 40, stops after 340. Train B: phase 462, runs on.
  // First sample of a ping sits exactly on the threshold (R3 boundary).
  function automatic int mag_at(input int n);
    int off;
    off = -1;
    if (n >= 40 && n <= 342 && ((n - 40) % PER) < 3) off = (n - 40) % PER;
    if (n >= 462 && ((n - 462) % PER) < 3) off = (n - 462) % PER;
    if (off == 0) return THR;
    if (off > 0)  return THR + 500;
    return THR - 1;
  endfunction

  task automatic drive(input int n);
    @(negedge clk);
    // probes of capture / lock state seen by strobe n
    if (n == 120)  begin check(cap_en == 1'b0, "R4 wait cap_en", cap_en, 0);
                         check(locked == 1'b1, "R4 wait locked", locked, 1); end
    if (n == 135)  check(cap_en == 1'b1, "R5 track cap_en", cap_en, 1);
    if (n == 465)  begin check(cap_en == 1'b1, "R6 fallback cap_en", cap_en, 1);
                         check(locked == 1'b0, "R6 fallback locked", locked, 0); end
    if (n == 600)  check(cap_en == 1'b0, "R4 wait after bumped schedule", cap_en, 0);
    if (n == 950)  begin check(cap_en == 1'b1, "R7 debug cap_en", cap_en, 1);
                         check(locked == 1'b0, "R7 debug locked", locked, 0); end
    if (n == 1200) begin check(cap_en == 1'b1, "R8 search cap_en", cap_en, 1);
                         check(locked == 1'b0, "R8 search locked", locked, 0); end
    if (n == 1300) check(cap_en == 1'b0, "R4 wait after relock", cap_en, 0);
    if (n >= 110 && n <= 229 && cap_en) cap_a++;
    if (n >= 460 && n <= 651 && cap_en) cap_b++;
    if (n >= 900 && n <= 1149 && cap_en) cap_c++;
    smp_stb = 1'b1;
    smp_mag = MAG_W'(mag_at(n));
    cur_idx = n;
    @(negedge clk);
    smp_stb = 1'b0;
    if (n == 899)  debug_en = 1'b1;
    if (n == 1149) debug_en = 1'b0;
  endtask

  // Monitor: pops expected events as the design reports them.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ping_vld) begin
        if (exp_ping.size() == 0) check(1'b0, "R3 unexpected ping", int'(ping_ts), -1);
        else begin
          int e;
          e = exp_ping.pop_front();
          check(int'(ping_ts) == e, "R3 ping timestamp", int'(ping_ts), e);
          check(cur_idx == e, "R1 report follows strobe", cur_idx, e);
        end
      end
      if (dump_pulse) begin
        if (exp_dump.size() == 0) check(1'b0, "R7 unexpected dump", cur_idx, -1);
        else begin
          int e;
          e = exp_dump.pop_front();
          check(cur_idx == e, "R7 dump window end", cur_idx, e);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cur_idx, N_SMP - 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Expected reports: search hit, tracking hits (R2, R5), fallback and
    // earliest-in-window with bumped schedule (R6, R4), relock after debug (R8).
    exp_ping = '{40, 140, 240, 340, 462, 662, 762, 862, 1162, 1362, 1462};
    exp_dump = '{1004, 1109};
    repeat (4) @(negedge clk);
    check(cap_en == 1'b1, "R9 reset cap_en", cap_en, 1);
    check(locked == 1'b0, "R9 reset locked", locked, 0);
    check(ping_vld == 1'b0, "R9 reset ping_vld", ping_vld, 0);
    check(dump_pulse == 1'b0, "R9 reset dump", dump_pulse, 0);
    check(ping_ts == 32'd0, "R9 reset ping_ts", int'(ping_ts), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < N_SMP; n++) drive(n);
    repeat (3) @(negedge clk);
    check(cap_a == T_LEN, "R5 track length", cap_a, T_LEN);
    check(cap_b == S_LEN, "R2 search length", cap_b, S_LEN);
    check(cap_c == 250, "R7 continuous capture", cap_c, 250);
    check(exp_ping.size() == 0, "R3 missing pings", exp_ping.size(), 0);
    check(exp_dump.size() == 0, "R7 missing dumps", exp_dump.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule